// File: doc/BRIEF.md
# Multiplexed Address Latch and Bank Decoder

This block rebuilds a 16-bit memory address from a CPU that sends it in two halves over an 8-bit bus. The CPU first places the high byte on the bus while it pulses a capture strobe. The block stores that byte on the clock edge and then joins it with the low byte, which the CPU drives onto the same lines next. A second strobe ends the access. Between the capture and that closing strobe, the block raises an address-valid qualifier.

From the rebuilt address the block drives one select line per 512-byte memory bank. Each bank has a 3-bit strap that gives its bank number, and a flag that places it in the low half or the high half of memory. A bank is selected when address bits 11..9 equal its strap and its half is not deselected. The low half is deselected while the utility-run mode is active or while address bit 15 is 1. In every other case the high half is deselected. Bits 12..14 take no part in decoding, so each bank appears again at several addresses within its half. A select is driven only while the address is valid. For that reason it cannot glitch during the high-byte phase.

Top module: `addr_latch_bank_dec`

## Requirements
- R1: While rst_ni is low, the stored high byte is 0, addr_valid_o is 0 and every bank_sel_o bit is 0.
- R2: On each rising clock edge where hi_strobe_i is 1, addr_o[15:8] takes the value of addr_bus_i. On every other edge, addr_o[15:8] keeps its value.
- R3: addr_o[7:0] follows addr_bus_i in the same cycle, with no register in between.
- R4: addr_valid_o is 1 in the cycle after a capture edge. It is 0 in any cycle where hi_strobe_i is 1.
- R5: addr_valid_o stays 1 through a cycle where end_strobe_i is 1, and becomes 0 after that edge. If both strobes are 1 at the same edge, the capture wins and the valid window continues.
- R6: Select bit i can be 1 only if addr_o[11:9] equals strap i. The strap for bank i is bank_num_i[3*i+2:3*i]. Address bits 12..14 have no effect on any select.
- R7: The low half is deselected when util_run_i is 1 or addr_o[15] is 1. A bank whose bank_hi_i bit is 0 belongs to the low half and cannot be selected while the low half is deselected. A bank whose bank_hi_i bit is 1 belongs to the high half and can be selected only while the low half is deselected.
- R8: All selects are 0 whenever addr_valid_o is 0.
- R9: Take two low-half banks strapped 0 and 1 as one 1K RAM, and a high-half bank strapped 0 as ROM. With util_run_i at 0, the RAM answers addresses 0x0000 to 0x03FF and the ROM answers 0x8000 to 0x81FF. With util_run_i at 1, the ROM also answers 0x0000 to 0x01FF and the RAM answers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_bus_i | input | 8 | Multiplexed address bus |
| hi_strobe_i | input | 1 | First timing pulse; the high byte is captured at the edge |
| end_strobe_i | input | 1 | Second timing pulse; closes the valid window |
| util_run_i | input | 1 | Utility-run mode; forces the low half to be deselected |
| bank_num_i | input | 12 | Bank-number straps, 3 bits per bank, bank 0 in the low bits |
| bank_hi_i | input | 4 | Half flag per bank (1 = high half) |
| addr_o | output | 16 | Rebuilt address |
| addr_valid_o | output | 1 | Address-stable qualifier |
| bank_sel_o | output | 4 | Per-bank selects |

## Verification
The bench builds the block with its default parameters: four banks, 3-bit straps, and the bank field at bit 9. It straps two banks with the same number 0, one in each half, so that only the half deselect tells them apart. The other two banks take numbers 1 and 5. The bench also sweeps addresses that differ only in bits 12..14. This arrangement reaches the RAM and ROM windows, the mirroring of each bank, the mode-forced swap of the two halves, and the case where both strobes land on the same edge.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  typedef enum logic {
    HALF_LOW  = 1'b0,
    HALF_HIGH = 1'b1
  } half_e;

  // true when the bank's half is currently allowed to respond
  function automatic logic half_enabled(input half_e half, input logic low_desel);
    return (half == HALF_HIGH) ? low_desel : ~low_desel;
  endfunction
endpackage

// File: rtl/addr_hi_latch.sv
module addr_hi_latch #(
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [BUS_W-1:0] hi_o
);
  logic [BUS_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hi_q <= '0;
    else if (cap_i) hi_q <= bus_i;
  end

  assign hi_o = hi_q;
endmodule

// File: rtl/addr_window_gen.sv
module addr_window_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_strobe_i,
  input  logic end_strobe_i,
  output logic valid_o
);
  logic open_q;

  // capture opens the window, the closing strobe ends it; capture wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           open_q <= 1'b0;
    else if (hi_strobe_i)  open_q <= 1'b1;
    else if (end_strobe_i) open_q <= 1'b0;
  end

  // high byte changes at the next edge while the capture strobe is up
  assign valid_o = open_q & ~hi_strobe_i;
endmodule

// File: rtl/bank_sel_unit.sv
module bank_sel_unit
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 3,
  parameter int BANK_LSB = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              valid_i,
  input  logic              low_desel_i,
  input  logic [BANK_W-1:0] strap_i,
  input  logic              hi_half_i,
  output logic              sel_o
);
  logic [BANK_W-1:0] field;
  logic              match;
  half_e             half;

  always_comb begin
    field = addr_i[BANK_LSB +: BANK_W];
    match = (field == strap_i);
    half  = half_e'(hi_half_i);
    sel_o = valid_i & match & half_enabled(half, low_desel_i);
  end
endmodule

// File: rtl/addr_latch_bank_dec.sv
module addr_latch_bank_dec #(
  parameter int BUS_W    = 8,
  parameter int N_BANK   = 4,
  parameter int BANK_W   = 3,
  parameter int BANK_LSB = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BUS_W-1:0]         addr_bus_i,
  input  logic                     hi_strobe_i,
  input  logic                     end_strobe_i,
  input  logic                     util_run_i,
  input  logic [N_BANK*BANK_W-1:0] bank_num_i,
  input  logic [N_BANK-1:0]        bank_hi_i,
  output logic [2*BUS_W-1:0]       addr_o,
  output logic                     addr_valid_o,
  output logic [N_BANK-1:0]        bank_sel_o
);
  localparam int ADDR_W = 2 * BUS_W;

  logic [BUS_W-1:0] hi_byte;
  logic             valid;
  logic             low_desel;

  addr_hi_latch #(.BUS_W(BUS_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (hi_strobe_i),
    .bus_i  (addr_bus_i),
    .hi_o   (hi_byte)
  );

  addr_window_gen u_win (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hi_strobe_i  (hi_strobe_i),
    .end_strobe_i (end_strobe_i),
    .valid_o      (valid)
  );

  assign addr_o       = {hi_byte, addr_bus_i};
  assign addr_valid_o = valid;
  assign low_desel    = util_run_i | addr_o[ADDR_W-1];

  for (genvar i = 0; i < N_BANK; i++) begin : g_bank
    bank_sel_unit #(
      .ADDR_W   (ADDR_W),
      .BANK_W   (BANK_W),
      .BANK_LSB (BANK_LSB)
    ) u_sel (
      .addr_i      (addr_o),
      .valid_i     (valid),
      .low_desel_i (low_desel),
      .strap_i     (bank_num_i[i*BANK_W +: BANK_W]),
      .hi_half_i   (bank_hi_i[i]),
      .sel_o       (bank_sel_o[i])
    );
  end
endmodule

// File: rtl/addr_latch_bank_dec_chk.sv
module addr_latch_bank_dec_chk #(
  parameter int BUS_W    = 8,
  parameter int N_BANK   = 4,
  parameter int BANK_W   = 3,
  parameter int BANK_LSB = 9
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [BUS_W-1:0]         addr_bus_i,
  input logic                     hi_strobe_i,
  input logic                     end_strobe_i,
  input logic                     util_run_i,
  input logic [N_BANK*BANK_W-1:0] bank_num_i,
  input logic [N_BANK-1:0]        bank_hi_i,
  input logic [2*BUS_W-1:0]       addr_o,
  input logic                     addr_valid_o,
  input logic [N_BANK-1:0]        bank_sel_o
);
  localparam int ADDR_W = 2 * BUS_W;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_strobe_i |=> addr_o[ADDR_W-1:BUS_W] == $past(addr_bus_i));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hi_strobe_i |=> $stable(addr_o[ADDR_W-1:BUS_W]));

  a_r4_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_strobe_i |=> (addr_valid_o == !hi_strobe_i));

  a_r4_low_in_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_strobe_i |-> !addr_valid_o);

  a_r5_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_strobe_i && !hi_strobe_i) |=> !addr_valid_o);

  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_o |-> bank_sel_o == '0);

  for (genvar i = 0; i < N_BANK; i++) begin : g_a
    a_r6_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_sel_o[i] |-> addr_o[BANK_LSB +: BANK_W] == bank_num_i[i*BANK_W +: BANK_W]);

    a_r7_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bank_sel_o[i] |-> (bank_hi_i[i] == (util_run_i || addr_o[ADDR_W-1])));
  end
endmodule

bind addr_latch_bank_dec addr_latch_bank_dec_chk #(
  .BUS_W(BUS_W), .N_BANK(N_BANK), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB)
) u_chk (.*);

// File: tb/addr_latch_bank_dec_test.sv
`timescale 1ns/1ps
module addr_latch_bank_dec_test;
  localparam int NB = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus = 0;
  logic        hs = 0, es = 0, util = 0;
  logic [11:0] straps;
  logic [3:0]  hif;
  logic [15:0] addr;
  logic        valid;
  logic [3:0]  sel;

  int checks = 0, fails = 0;
  int m_hi = 0;
  bit m_open = 0;
  int strap_v [NB] = '{0, 1, 0, 5};
  bit hi_v    [NB] = '{0, 0, 1, 1};
  bit done = 0;

  always #4 clk = ~clk;

  initial begin
    for (int i = 0; i < NB; i++) begin
      straps[i*3 +: 3] = strap_v[i][2:0];
      hif[i] = hi_v[i];
    end
  end

  addr_latch_bank_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_bus_i(bus), .hi_strobe_i(hs),
    .end_strobe_i(es), .util_run_i(util), .bank_num_i(straps), .bank_hi_i(hif),
    .addr_o(addr), .addr_valid_o(valid), .bank_sel_o(sel));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model of the outputs for the current inputs
  task automatic compare(input string tag);
    int a, v, s, f;
    bit ld;
    a  = m_hi * 256 + bus;
    v  = (m_open && !hs) ? 1 : 0;
    ld = util || (a >= 32768);
    s  = 0;
    f  = (a / 512) % 8;
    for (int i = 0; i < NB; i++)
      if (v == 1 && f == strap_v[i] && (hi_v[i] ? ld : !ld)) s += (1 << i);
    chk({tag, "/R2R3 addr"}, addr, a);
    chk({tag, "/R4R5 valid"}, valid, v);
    chk({tag, "/R6R7R8 sel"}, sel, s);
  endtask

  // inputs are driven after the falling edge, compared, then the model steps at the rising edge
  task automatic step(input bit h, input bit e, input logic [7:0] b, input bit u, input string tag);
    hs = h; es = e; bus = b; util = u;
    #1 compare(tag);
    @(posedge clk);
    if (h) begin m_hi = b; m_open = 1; end
    else if (e) m_open = 0;
    @(negedge clk);
  endtask

  task automatic access(input logic [15:0] a, input bit u, input string tag);
    step(1, 0, a[15:8], u, tag);
    step(0, 0, a[7:0], u, tag);
    step(0, 1, a[7:0], u, tag);
    step(0, 0, 8'h00, u, tag);
  endtask

  task automatic probe_sel(input logic [15:0] a, input bit u, input int exp, input string tag);
    step(1, 0, a[15:8], u, tag);
    hs = 0; bus = a[7:0]; util = u;
    #1 chk(tag, sel, exp);
    step(0, 1, a[7:0], u, tag);
    step(0, 0, 8'h00, u, tag);
  endtask

  initial begin
    #300000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf;
    // R1: reset state, with strobes active and the bus driven
    hs = 1; bus = 8'hA5;
    @(posedge clk); @(negedge clk);
    #1;
    chk("R1 hi byte", addr[15:8], 0);
    chk("R1 valid", valid, 0);
    chk("R1 sel", sel, 0);
    hs = 0;
    @(negedge clk); rst_n = 1;

    // R3: the low byte passes straight through
    step(0, 0, 8'h3C, 0, "R3 passthru");
    step(0, 0, 8'hC3, 0, "R3 passthru");

    // R9: RAM 1K window and ROM window
    probe_sel(16'h0000, 0, 4'b0001, "R9 ram lo");
    probe_sel(16'h03FF, 0, 4'b0010, "R9 ram top");
    probe_sel(16'h0400, 0, 4'b0000, "R9 ram gap");
    probe_sel(16'h8000, 0, 4'b0100, "R9 rom base");
    probe_sel(16'h81FF, 0, 4'b0100, "R9 rom top");
    probe_sel(16'h0100, 1, 4'b0100, "R9 util rom low");
    // R6: bits 12..14 mirror, strap 5 in the high half
    probe_sel(16'h7200, 0, 4'b0010, "R6 mirror");
    probe_sel(16'hFA00, 0, 4'b1000, "R6 strap5");
    // R7: a high-half address while util is set keeps the low half off
    probe_sel(16'h8200, 1, 4'b0000, "R7 hi none");

    // R5: both strobes at the same edge, capture wins
    step(1, 0, 8'h80, 0, "R5 both");
    step(1, 1, 8'h02, 0, "R5 both");
    step(0, 0, 8'h10, 0, "R5 both");
    step(0, 1, 8'h10, 0, "R5 end");
    step(0, 0, 8'h10, 0, "R5 after");
    // R2: the high byte holds with no capture
    step(0, 0, 8'hFF, 0, "R2 hold");

    // mixed sweep with the model
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[1] & lf[2], lf[15:8] ^ lf[7:0], lf[3] & lf[4], "R4R6R7R8 sweep");
      if (lf[5]) access(lf, lf[6], "R2R7 sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule